// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block produces every control strobe of a small multicycle load/store processor. The strobes are not decoded from a hardwired state register. A micro-program counter selects one word of a constant control store written into the RTL. Each word has two parts. The first is a packed group of datapath control signals. The second is a 2-bit sequencing field that names the source of the next micro-address.

The sequencing field has four values. `00` steps to the next sequential word. `01` looks up the main dispatch table, keyed by the 6-bit opcode. `10` looks up the memory-operation dispatch table, which separates loads from stores. `11` goes back to word 0, the instruction fetch word. An opcode that is missing from a dispatch table sends the sequencer back to fetch. Every micro-word stands for exactly one state of the equivalent control machine. The containing datapath reads the strobes while each word is current and returns the instruction's opcode on `opcode`.

Top module: `useq_ctrl`

## Requirements
- R1: A synchronous active-high reset loads micro-address 0. In the first cycle after reset is released the outputs show the fetch word, even if reset arrived part-way through an instruction.
- R2: The fetch word drives these values: mem_rd=1, mem_addr_alu=0, ir_load=1, pc_load=1, pc_cond=0, pc_src=00, alu_op=00, alu_a_sel=0, alu_b_sel=01. Every other strobe is 0.
- R3: The word after fetch is always the decode word. It drives alu_a_sel=0, alu_b_sel=11 and alu_op=00, and every other strobe is 0.
- R4: After decode, the opcode selects the next word. 0x00 goes to the register-ALU compute word. 0x23 and 0x2B go to the address-calculation word. 0x04 goes to the branch word. 0x02 goes to the jump word. Every other opcode returns to fetch.
- R5: For opcode 0x00 the sequence has two words and then returns to fetch. The compute word drives alu_a_sel=1, alu_b_sel=00 and alu_op=10. The write-back word drives rf_we=1, rf_dst_rd=1 and rf_wb_mem=0.
- R6: For opcode 0x23 the sequence has three words and then returns to fetch. The address word drives alu_a_sel=1, alu_b_sel=10 and alu_op=00. The read word drives mem_rd=1 and mem_addr_alu=1. The write-back word drives rf_we=1, rf_dst_rd=0 and rf_wb_mem=1.
- R7: For opcode 0x2B the sequence is the same address word, then a write word driving mem_wr=1 and mem_addr_alu=1, then fetch.
- R8: The branch word drives alu_a_sel=1, alu_b_sel=00, alu_op=01, pc_cond=1 and pc_src=01, and is followed by fetch.
- R9: The jump word drives pc_load=1 and pc_src=10, and is followed by fetch.
- R10: The opcode is consulted only in the decode and address-calculation words. A change of opcode in any other word has no effect on the sequence.
- R11: mem_rd and mem_wr are never both 1. rf_we and mem_wr are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the current instruction |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr_alu | output | 1 | Memory address from ALU result register (1) or PC (0) |
| ir_load | output | 1 | Load instruction register |
| pc_load | output | 1 | Unconditional PC write |
| pc_cond | output | 1 | PC write qualified by ALU zero |
| pc_src | output | 2 | PC source: 00 ALU, 01 ALU result register, 10 jump target |
| alu_op | output | 2 | 00 add, 01 subtract, 10 function-field controlled |
| alu_a_sel | output | 1 | ALU A input: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU B input: 00 register B, 01 constant 4, 10 immediate, 11 shifted immediate |
| rf_we | output | 1 | Register file write enable |
| rf_dst_rd | output | 1 | Write destination is rd (1) or rt (0) |
| rf_wb_mem | output | 1 | Write data from memory data register (1) or ALU result register (0) |

## Verification
Every micro-word drives a distinct strobe pattern. A wrong micro-address therefore shows on the ports in the same cycle the sequencer reaches it, and there is no hidden state that stays invisible for a cycle. A broken dispatch entry or sequencing field shows as a wrong pattern one cycle after decode or address calculation. A word that fails to return to fetch shows one cycle after the final word of its instruction. The bench sweeps all 64 opcodes back to back. In each instruction it corrupts the opcode once the last dispatch has been taken. It also checks a reset that arrives mid-instruction.

// File: rtl/useq_pkg.sv
package useq_pkg;
    localparam int OPC_W = 6;
    localparam int UPC_W = 4;
    localparam int SEQ_W = 2;
    localparam int STORE_DEPTH = 1 << UPC_W;

    typedef logic [UPC_W-1:0] uaddr_t;
    typedef logic [OPC_W-1:0] opc_t;

    typedef enum logic [SEQ_W-1:0] {
        SEQ_STEP      = 2'b00,
        SEQ_DISP_MAIN = 2'b01,
        SEQ_DISP_MEM  = 2'b10,
        SEQ_RESTART   = 2'b11
    } seq_e;

    typedef struct packed {
        logic       mem_rd;
        logic       mem_wr;
        logic       mem_addr_alu;
        logic       ir_load;
        logic       pc_load;
        logic       pc_cond;
        logic [1:0] pc_src;
        logic [1:0] alu_op;
        logic       alu_a_sel;
        logic [1:0] alu_b_sel;
        logic       rf_we;
        logic       rf_dst_rd;
        logic       rf_wb_mem;
    } ctrl_t;

    typedef struct packed {
        ctrl_t ctrl;
        seq_e  seq;
    } uword_t;

    localparam uaddr_t UA_FETCH  = uaddr_t'(0);
    localparam uaddr_t UA_DECODE = uaddr_t'(1);
    localparam uaddr_t UA_MADDR  = uaddr_t'(2);
    localparam uaddr_t UA_LDRD   = uaddr_t'(3);
    localparam uaddr_t UA_LDWB   = uaddr_t'(4);
    localparam uaddr_t UA_STWR   = uaddr_t'(5);
    localparam uaddr_t UA_REXE   = uaddr_t'(6);
    localparam uaddr_t UA_RWB    = uaddr_t'(7);
    localparam uaddr_t UA_BEQ    = uaddr_t'(8);
    localparam uaddr_t UA_JMP    = uaddr_t'(9);

    localparam opc_t OP_RTYPE = 6'h00;
    localparam opc_t OP_JMP   = 6'h02;
    localparam opc_t OP_BEQ   = 6'h04;
    localparam opc_t OP_LOAD  = 6'h23;
    localparam opc_t OP_STORE = 6'h2B;

    // Contents of one control-store word; unused addresses fall back to fetch.
    function automatic uword_t store_word(uaddr_t a);
        uword_t w;
        w.ctrl = '0;
        w.seq  = SEQ_RESTART;
        case (a)
            UA_FETCH: begin
                w.ctrl.mem_rd    = 1'b1;
                w.ctrl.ir_load   = 1'b1;
                w.ctrl.pc_load   = 1'b1;
                w.ctrl.alu_b_sel = 2'b01;
                w.seq            = SEQ_STEP;
            end
            UA_DECODE: begin
                w.ctrl.alu_b_sel = 2'b11;
                w.seq            = SEQ_DISP_MAIN;
            end
            UA_MADDR: begin
                w.ctrl.alu_a_sel = 1'b1;
                w.ctrl.alu_b_sel = 2'b10;
                w.seq            = SEQ_DISP_MEM;
            end
            UA_LDRD: begin
                w.ctrl.mem_rd       = 1'b1;
                w.ctrl.mem_addr_alu = 1'b1;
                w.seq               = SEQ_STEP;
            end
            UA_LDWB: begin
                w.ctrl.rf_we     = 1'b1;
                w.ctrl.rf_wb_mem = 1'b1;
            end
            UA_STWR: begin
                w.ctrl.mem_wr       = 1'b1;
                w.ctrl.mem_addr_alu = 1'b1;
            end
            UA_REXE: begin
                w.ctrl.alu_a_sel = 1'b1;
                w.ctrl.alu_op    = 2'b10;
                w.seq            = SEQ_STEP;
            end
            UA_RWB: begin
                w.ctrl.rf_we     = 1'b1;
                w.ctrl.rf_dst_rd = 1'b1;
            end
            UA_BEQ: begin
                w.ctrl.alu_a_sel = 1'b1;
                w.ctrl.alu_op    = 2'b01;
                w.ctrl.pc_cond   = 1'b1;
                w.ctrl.pc_src    = 2'b01;
            end
            UA_JMP: begin
                w.ctrl.pc_load = 1'b1;
                w.ctrl.pc_src  = 2'b10;
            end
            default: ;
        endcase
        return w;
    endfunction

    function automatic uaddr_t dispatch_main(opc_t op);
        case (op)
            OP_RTYPE:          return UA_REXE;
            OP_LOAD, OP_STORE: return UA_MADDR;
            OP_BEQ:            return UA_BEQ;
            OP_JMP:            return UA_JMP;
            default:           return UA_FETCH;
        endcase
    endfunction

    function automatic uaddr_t dispatch_mem(opc_t op);
        case (op)
            OP_LOAD:  return UA_LDRD;
            OP_STORE: return UA_STWR;
            default:  return UA_FETCH;
        endcase
    endfunction
endpackage

// File: rtl/useq_store.sv
module useq_store
    import useq_pkg::*;
#(
    parameter int DEPTH = STORE_DEPTH
) (
    input  uaddr_t upc,
    output uword_t word
);
    uword_t rom [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        assign rom[i] = store_word(uaddr_t'(i));
    end

    assign word = rom[upc];
endmodule

// File: rtl/useq_next.sv
module useq_next
    import useq_pkg::*;
(
    input  uaddr_t upc,
    input  seq_e   seq,
    input  opc_t   opcode,
    output uaddr_t nxt
);
    uaddr_t via_main;
    uaddr_t via_mem;

    assign via_main = dispatch_main(opcode);
    assign via_mem  = dispatch_mem(opcode);

    always_comb begin
        case (seq)
            SEQ_STEP:      nxt = upc + uaddr_t'(1);
            SEQ_DISP_MAIN: nxt = via_main;
            SEQ_DISP_MEM:  nxt = via_mem;
            default:       nxt = UA_FETCH;
        endcase
    end

    // Unknown opcodes must fall back to fetch (R4).
    always_comb begin
        if (seq == SEQ_DISP_MAIN && opcode != OP_RTYPE && opcode != OP_LOAD &&
            opcode != OP_STORE && opcode != OP_BEQ && opcode != OP_JMP)
            assert_unknown_fetch_R4: assert (nxt == UA_FETCH);
    end
endmodule

// File: rtl/useq_upc_reg.sv
module useq_upc_reg
    import useq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  uaddr_t nxt,
    output uaddr_t upc
);
    always_ff @(posedge clk) begin
        if (rst) upc <= UA_FETCH;
        else     upc <= nxt;
    end
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
    import useq_pkg::*;
#(
    parameter int OPCODE_W = OPC_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [OPCODE_W-1:0] opcode,
    output logic                mem_rd,
    output logic                mem_wr,
    output logic                mem_addr_alu,
    output logic                ir_load,
    output logic                pc_load,
    output logic                pc_cond,
    output logic [1:0]          pc_src,
    output logic [1:0]          alu_op,
    output logic                alu_a_sel,
    output logic [1:0]          alu_b_sel,
    output logic                rf_we,
    output logic                rf_dst_rd,
    output logic                rf_wb_mem
);
    uaddr_t upc;
    uaddr_t nxt;
    uword_t word;

    useq_store u_store (
        .upc  (upc),
        .word (word)
    );

    useq_next u_next (
        .upc    (upc),
        .seq    (word.seq),
        .opcode (opc_t'(opcode)),
        .nxt    (nxt)
    );

    useq_upc_reg u_upc (
        .clk (clk),
        .rst (rst),
        .nxt (nxt),
        .upc (upc)
    );

    assign mem_rd       = word.ctrl.mem_rd;
    assign mem_wr       = word.ctrl.mem_wr;
    assign mem_addr_alu = word.ctrl.mem_addr_alu;
    assign ir_load      = word.ctrl.ir_load;
    assign pc_load      = word.ctrl.pc_load;
    assign pc_cond      = word.ctrl.pc_cond;
    assign pc_src       = word.ctrl.pc_src;
    assign alu_op       = word.ctrl.alu_op;
    assign alu_a_sel    = word.ctrl.alu_a_sel;
    assign alu_b_sel    = word.ctrl.alu_b_sel;
    assign rf_we        = word.ctrl.rf_we;
    assign rf_dst_rd    = word.ctrl.rf_dst_rd;
    assign rf_wb_mem    = word.ctrl.rf_wb_mem;

    // Checks
    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    always @(posedge clk) begin
        if (rst_q === 1'b1)
            assert_reset_fetch_R1: assert (upc == UA_FETCH && ir_load && mem_rd);
    end

    assert_decode_after_fetch_R3: assert property (@(posedge clk) disable iff (rst)
        (upc == UA_FETCH) |=> (upc == UA_DECODE));

    assert_rf_write_ends_R5: assert property (@(posedge clk) disable iff (rst)
        rf_we |=> (upc == UA_FETCH));

    assert_store_ends_R7: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> (upc == UA_FETCH));

    assert_no_mem_clash_R11: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr) && !(rf_we && mem_wr));
endmodule

// File: tb/useq_ctrl_test.sv
module useq_ctrl_test;
    localparam int CLK_PERIOD = 10;

    // Word labels
    localparam int W_F = 0, W_D = 1, W_MA = 2, W_LR = 3, W_LW = 4,
                   W_SW = 5, W_RC = 6, W_RW = 7, W_BR = 8, W_JP = 9;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [5:0] opcode = 6'h00;
    logic mem_rd, mem_wr, mem_addr_alu, ir_load, pc_load, pc_cond;
    logic [1:0] pc_src, alu_op, alu_b_sel;
    logic alu_a_sel, rf_we, rf_dst_rd, rf_wb_mem;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    useq_ctrl uut (
        .clk(clk), .rst(rst), .opcode(opcode),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr_alu(mem_addr_alu),
        .ir_load(ir_load), .pc_load(pc_load), .pc_cond(pc_cond),
        .pc_src(pc_src), .alu_op(alu_op), .alu_a_sel(alu_a_sel),
        .alu_b_sel(alu_b_sel), .rf_we(rf_we), .rf_dst_rd(rf_dst_rd),
        .rf_wb_mem(rf_wb_mem)
    );

    // Order: mem_rd mem_wr mem_addr_alu ir_load pc_load pc_cond pc_src alu_op alu_a_sel alu_b_sel rf_we rf_dst_rd rf_wb_mem
    function automatic logic [15:0] expect_of(int w);
        case (w)
            W_F:  return {1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,2'b00,2'b00,1'b0,2'b01,1'b0,1'b0,1'b0};
            W_D:  return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,1'b0,2'b11,1'b0,1'b0,1'b0};
            W_MA: return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,1'b1,2'b10,1'b0,1'b0,1'b0};
            W_LR: return {1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,2'b00,2'b00,1'b0,2'b00,1'b0,1'b0,1'b0};
            W_LW: return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,1'b0,2'b00,1'b1,1'b0,1'b1};
            W_SW: return {1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,2'b00,2'b00,1'b0,2'b00,1'b0,1'b0,1'b0};
            W_RC: return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b10,1'b1,2'b00,1'b0,1'b0,1'b0};
            W_RW: return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,1'b0,2'b00,1'b1,1'b1,1'b0};
            W_BR: return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b01,2'b01,1'b1,2'b00,1'b0,1'b0,1'b0};
            default: return {1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,2'b10,2'b00,1'b0,2'b00,1'b0,1'b0,1'b0};
        endcase
    endfunction

    function automatic logic [15:0] observed();
        return {mem_rd, mem_wr, mem_addr_alu, ir_load, pc_load, pc_cond, pc_src,
                alu_op, alu_a_sel, alu_b_sel, rf_we, rf_dst_rd, rf_wb_mem};
    endfunction

    task automatic check_word(int w, string req, logic [5:0] op);
        logic [15:0] got;
        logic [15:0] exp;
        got = observed();
        exp = expect_of(w);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s opcode=%02h word=%0d actual=%04h expected=%04h", req, op, w, got, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int path [4];
        int plen;
        rst = 1'b1;
        step();
        step();
        rst = 1'b0;
        // R1: fetch word visible after reset; R2 contents of fetch
        check_word(W_F, "R1", opcode);

        for (int op = 0; op < 64; op++) begin
            opcode = 6'(op);
            check_word(W_F, "R2", opcode);
            step();
            check_word(W_D, "R3", opcode);
            plen = 0;
            case (op)
                'h00: begin path[0] = W_RC; path[1] = W_RW; plen = 2; end                   // R5
                'h23: begin path[0] = W_MA; path[1] = W_LR; path[2] = W_LW; plen = 3; end   // R6
                'h2B: begin path[0] = W_MA; path[1] = W_SW; plen = 2; end                   // R7
                'h04: begin path[0] = W_BR; plen = 1; end                                   // R8
                'h02: begin path[0] = W_JP; plen = 1; end                                   // R9
                default: plen = 0;                                                          // R4 unknown
            endcase
            for (int k = 0; k < plen; k++) begin
                step();
                check_word(path[k], k == 0 ? "R4" : "R5-R9 path", 6'(op));
                // R10: once past the last dispatch, a garbage opcode must not matter
                if (path[k] != W_MA) opcode = ~6'(op);
            end
            step();
            check_word(W_F, "R10 return", 6'(op));
        end

        // R1: reset in the middle of a load
        opcode = 6'h23;
        step();
        check_word(W_D, "R3", opcode);
        step();
        check_word(W_MA, "R6", opcode);
        rst = 1'b1;
        step();
        rst = 1'b0;
        check_word(W_F, "R1 mid", opcode);
        step();
        check_word(W_D, "R3", opcode);
        // R11 covered by bench too: load read word after reset restart
        step();
        check_word(W_MA, "R6", opcode);
        step();
        check_word(W_LR, "R6", opcode);
        checks++;
        if (mem_rd && mem_wr) begin
            errors++;
            $display("FAIL R11 actual=rd&wr expected=exclusive");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule